// File: doc/BRIEF.md
# Dual-Retire Reorder Buffer

This block is the in-order completion queue of an out-of-order integer core. Each instruction that leaves dispatch claims the next free slot of an eight-slot circular queue. The slot index is handed back as the rename tag, and waiting instructions use it to find their operand. Execution units write each result into its slot through two writeback ports. Two operand read ports let dispatch fetch a renamed source by tag. A result written back in the same cycle is seen at once on these ports.

Each cycle the two oldest slots are examined. The oldest retires once its result has arrived, and the one after it retires in the same cycle only if the oldest also does. A retiring slot drives one of two register-file write ports, the older instruction always on port 0. A slot marked as the program-ending return instruction retires without a register write. It raises a sticky `done` output and stops all further retirement. If every slot is taken, `alloc_ready` drops and allocation requests are ignored.

Top module: `rob_dual_commit`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, both commit write enables are 0, `done` is 0, and a read of any tag reports not ready.
- R2: Each accepted allocation (`alloc_valid` with `alloc_ready` high) returns on `alloc_tag` the current tail slot index, and the next tag is that index plus one.
- R3: With all eight slots occupied, `alloc_ready` is 0 and an allocation request changes nothing: the tag does not advance and no occupied slot is overwritten.
- R4: A read port reports `ready`=1 and the stored result for a slot whose writeback has completed, and `ready`=0 for an allocated slot still awaiting its result.
- R5: When a writeback port writes slot T in the same cycle that a read port asks for T, that read returns `ready`=1 and the data being written. Port 0 takes priority over port 1.
- R6: No slot retires before the oldest slot has its result. A younger completed slot waits behind an incomplete head.
- R7: When the two oldest slots are both complete, both retire in one cycle. The older one goes on commit port 0 and the younger on commit port 1, each with its destination register (0..15) and 32-bit result.
- R8: Commit port 1 is never active unless commit port 0 is active in the same cycle.
- R9: A retiring return slot drives no register write, and the slot after it does not retire in that cycle. `done` rises in the following cycle and stays high, and nothing retires afterwards.
- R10: Tags wrap from 7 back to 0, and allocation, writeback and retirement behave identically across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_dest | input | 4 | Destination register of the dispatching instruction |
| alloc_ret | input | 1 | Dispatching instruction is the program-ending return |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | 3 | Slot index given to the dispatching instruction |
| wb0_valid | input | 1 | Writeback port 0 active |
| wb0_tag | input | 3 | Slot written by port 0 |
| wb0_data | input | 32 | Result on port 0 |
| wb1_valid | input | 1 | Writeback port 1 active |
| wb1_tag | input | 3 | Slot written by port 1 |
| wb1_data | input | 32 | Result on port 1 |
| rd0_tag | input | 3 | Slot looked up by read port 0 |
| rd0_ready | output | 1 | Read port 0 result available |
| rd0_data | output | 32 | Read port 0 result |
| rd1_tag | input | 3 | Slot looked up by read port 1 |
| rd1_ready | output | 1 | Read port 1 result available |
| rd1_data | output | 32 | Read port 1 result |
| commit0_we | output | 1 | Register write from the oldest retiring slot |
| commit0_reg | output | 4 | Register index for commit port 0 |
| commit0_data | output | 32 | Data for commit port 0 |
| commit1_we | output | 1 | Register write from the second retiring slot |
| commit1_reg | output | 4 | Register index for commit port 1 |
| commit1_data | output | 32 | Data for commit port 1 |
| done | output | 1 | Return instruction has retired |

## Verification
Three outputs are combinational on the current inputs: `alloc_tag`/`alloc_ready`, the bypass path on the read ports and the commit ports. Each is sampled one time unit after the falling edge at which its stimulus is applied. A writeback lands at the next rising edge. Its slot therefore shows up on the commit ports in the cycle after that edge. Retirement takes effect at the edge that ends that cycle, and `done` is sampled in the cycle after it. The bench walks every allocation burst length from one to eight, which wraps the tags several times. It writes results youngest-first, so the head completes last, and then expects pairs of commits in exactly the cycles that follow.

// File: rtl/rob_dual_commit.sv
module rob_dual_commit #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              alloc_ret,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb0_valid,
  input  logic [TAG_W-1:0]  wb0_tag,
  input  logic [DATA_W-1:0] wb0_data,
  input  logic              wb1_valid,
  input  logic [TAG_W-1:0]  wb1_tag,
  input  logic [DATA_W-1:0] wb1_data,
  input  logic [TAG_W-1:0]  rd0_tag,
  output logic              rd0_ready,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [TAG_W-1:0]  rd1_tag,
  output logic              rd1_ready,
  output logic [DATA_W-1:0] rd1_data,
  output logic              commit0_we,
  output logic [REG_W-1:0]  commit0_reg,
  output logic [DATA_W-1:0] commit0_data,
  output logic              commit1_we,
  output logic [REG_W-1:0]  commit1_reg,
  output logic [DATA_W-1:0] commit1_data,
  output logic              done
);
  localparam int PTR_W = TAG_W + 1;

  logic [PTR_W-1:0]  head_q, tail_q;
  logic [DEPTH-1:0]  vld_q, cmp_q, ret_q;
  logic [REG_W-1:0]  dst_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic              done_q;

  logic [TAG_W-1:0] h0, h1, t0;
  logic full, alloc_fire, take0, take1, halt_set;
  logic wb0_ok, wb1_ok;

  assign h0 = head_q[TAG_W-1:0];
  assign h1 = h0 + 1'b1;
  assign t0 = tail_q[TAG_W-1:0];

  assign full        = (head_q[TAG_W] != tail_q[TAG_W]) && (h0 == t0);
  assign alloc_ready = !full;
  assign alloc_tag   = t0;
  assign alloc_fire  = alloc_valid && !full;

  assign wb0_ok = wb0_valid && vld_q[wb0_tag];
  assign wb1_ok = wb1_valid && vld_q[wb1_tag];

  assign take0 = vld_q[h0] && cmp_q[h0] && !done_q;
  assign take1 = take0 && !ret_q[h0] && vld_q[h1] && cmp_q[h1];
  assign halt_set = (take0 && ret_q[h0]) || (take1 && ret_q[h1]);

  assign commit0_we   = take0 && !ret_q[h0];
  assign commit0_reg  = dst_q[h0];
  assign commit0_data = dat_q[h0];
  assign commit1_we   = take1 && !ret_q[h1];
  assign commit1_reg  = dst_q[h1];
  assign commit1_data = dat_q[h1];
  assign done         = done_q;

  always_comb begin
    rd0_ready = cmp_q[rd0_tag];
    rd0_data  = dat_q[rd0_tag];
    if (wb1_valid && wb1_tag == rd0_tag) begin
      rd0_ready = 1'b1;
      rd0_data  = wb1_data;
    end
    if (wb0_valid && wb0_tag == rd0_tag) begin
      rd0_ready = 1'b1;
      rd0_data  = wb0_data;
    end
  end

  always_comb begin
    rd1_ready = cmp_q[rd1_tag];
    rd1_data  = dat_q[rd1_tag];
    if (wb1_valid && wb1_tag == rd1_tag) begin
      rd1_ready = 1'b1;
      rd1_data  = wb1_data;
    end
    if (wb0_valid && wb0_tag == rd1_tag) begin
      rd1_ready = 1'b1;
      rd1_data  = wb0_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      vld_q  <= '0;
      cmp_q  <= '0;
      ret_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (alloc_fire) begin
        vld_q[t0] <= 1'b1;
        cmp_q[t0] <= 1'b0;
        ret_q[t0] <= alloc_ret;
        tail_q    <= tail_q + 1'b1;
      end
      if (wb1_ok) cmp_q[wb1_tag] <= 1'b1;
      if (wb0_ok) cmp_q[wb0_tag] <= 1'b1;
      if (take0) begin
        vld_q[h0] <= 1'b0;
        cmp_q[h0] <= 1'b0;
      end
      if (take1) begin
        vld_q[h1] <= 1'b0;
        cmp_q[h1] <= 1'b0;
      end
      head_q <= head_q + PTR_W'(take0) + PTR_W'(take1);
      if (halt_set) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) dst_q[t0] <= alloc_dest;
    if (wb1_ok) dat_q[wb1_tag] <= wb1_data;
    if (wb0_ok) dat_q[wb0_tag] <= wb0_data;
  end
endmodule

// File: rtl/rob_dual_commit_chk.sv
module rob_dual_commit_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int TAG_W  = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic [TAG_W-1:0]  alloc_tag,
  input logic              wb0_valid,
  input logic [TAG_W-1:0]  wb0_tag,
  input logic [DATA_W-1:0] wb0_data,
  input logic [TAG_W-1:0]  rd0_tag,
  input logic              rd0_ready,
  input logic [DATA_W-1:0] rd0_data,
  input logic              commit0_we,
  input logic              commit1_we,
  input logic              done
);
  assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_tag == TAG_W'($past(alloc_tag) + 1'b1));

  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> $stable(alloc_tag));

  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb0_valid && wb0_tag == rd0_tag) |-> (rd0_ready && rd0_data == wb0_data));

  assert_pair_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit1_we |-> commit0_we);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_halted_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!commit0_we && !commit1_we));
endmodule

bind rob_dual_commit rob_dual_commit_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .wb0_valid(wb0_valid), .wb0_tag(wb0_tag), .wb0_data(wb0_data),
  .rd0_tag(rd0_tag), .rd0_ready(rd0_ready), .rd0_data(rd0_data),
  .commit0_we(commit0_we), .commit1_we(commit1_we), .done(done)
);

// File: tb/test_rob_dual_commit.sv
`timescale 1ns/1ps
module test_rob_dual_commit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [3:0]  alloc_dest = '0;
  logic        alloc_ret = 1'b0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        wb0_valid = 1'b0;
  logic [2:0]  wb0_tag = '0;
  logic [31:0] wb0_data = '0;
  logic        wb1_valid = 1'b0;
  logic [2:0]  wb1_tag = '0;
  logic [31:0] wb1_data = '0;
  logic [2:0]  rd0_tag = '0;
  logic        rd0_ready;
  logic [31:0] rd0_data;
  logic [2:0]  rd1_tag = '0;
  logic        rd1_ready;
  logic [31:0] rd1_data;
  logic        commit0_we, commit1_we, done;
  logic [3:0]  commit0_reg, commit1_reg;
  logic [31:0] commit0_data, commit1_data;

  int n_cmp = 0;
  int n_bad = 0;
  int base = 0;

  always #2.5 clk = ~clk;

  rob_dual_commit i_rob_dual_commit (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_dest(alloc_dest), .alloc_ret(alloc_ret),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wb0_valid(wb0_valid), .wb0_tag(wb0_tag), .wb0_data(wb0_data),
    .wb1_valid(wb1_valid), .wb1_tag(wb1_tag), .wb1_data(wb1_data),
    .rd0_tag(rd0_tag), .rd0_ready(rd0_ready), .rd0_data(rd0_data),
    .rd1_tag(rd1_tag), .rd1_ready(rd1_ready), .rd1_data(rd1_data),
    .commit0_we(commit0_we), .commit0_reg(commit0_reg), .commit0_data(commit0_data),
    .commit1_we(commit1_we), .commit1_reg(commit1_reg), .commit1_data(commit1_data),
    .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] val(input int n, input int k);
    return 32'hC0DE_0000 + 32'(n * 256 + k * 7);
  endfunction

  function automatic logic [3:0] dreg(input int n, input int k);
    return 4'((n + k * 3) % 16);
  endfunction

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 ready", 32'(alloc_ready), 1);
    chk("R1 tag", 32'(alloc_tag), 0);
    chk("R1 c0", 32'(commit0_we), 0);
    chk("R1 c1", 32'(commit1_we), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 rd", 32'(rd0_ready), 0);
    @(posedge clk);

    for (int n = 1; n <= 8; n++) begin
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        alloc_valid = 1'b1; alloc_dest = dreg(n, k); alloc_ret = 1'b0;
        #1;
        chk("R2 ready", 32'(alloc_ready), 1);
        chk("R2 R10 tag", 32'(alloc_tag), 32'((base + k) % 8));
        @(posedge clk);
      end
      @(negedge clk);
      alloc_valid = 1'b0;
      if (n == 8) begin
        alloc_valid = 1'b1; alloc_dest = 4'hF;
        #1;
        chk("R3 full", 32'(alloc_ready), 0);
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 1'b0;
      end
      #1;
      chk("R3 tag held", 32'(alloc_tag), 32'((base + n) % 8));
      rd0_tag = 3'((base) % 8);
      #1;
      chk("R4 pending", 32'(rd0_ready), 0);
      @(posedge clk);
      for (int j = n - 1; j >= 0; j--) begin
        @(negedge clk);
        wb0_valid = 1'b0; wb1_valid = 1'b0;
        if (j % 2 == 0) begin
          wb0_valid = 1'b1; wb0_tag = 3'((base + j) % 8); wb0_data = val(n, j);
          rd0_tag = wb0_tag; rd1_tag = 3'((base + j + 1) % 8);
          #1;
          chk("R5 rd0 rdy", 32'(rd0_ready), 1);
          chk("R5 rd0 data", rd0_data, val(n, j));
          if (j < n - 1) begin
            chk("R4 rd1 rdy", 32'(rd1_ready), 1);
            chk("R4 rd1 data", rd1_data, val(n, j + 1));
          end
        end else begin
          wb1_valid = 1'b1; wb1_tag = 3'((base + j) % 8); wb1_data = val(n, j);
          rd1_tag = wb1_tag; rd0_tag = 3'((base + j + 1) % 8);
          #1;
          chk("R5 rd1 rdy", 32'(rd1_ready), 1);
          chk("R5 rd1 data", rd1_data, val(n, j));
          if (j < n - 1) begin
            chk("R4 rd0 rdy", 32'(rd0_ready), 1);
            chk("R4 rd0 data", rd0_data, val(n, j + 1));
          end
        end
        chk("R6 head blocks", 32'(commit0_we), 0);
        @(posedge clk);
      end
      @(negedge clk);
      wb0_valid = 1'b0; wb1_valid = 1'b0;
      for (int p = 0; p < n; p += 2) begin
        if (p > 0) @(negedge clk);
        #1;
        chk("R7 c0 we", 32'(commit0_we), 1);
        chk("R7 c0 reg", 32'(commit0_reg), 32'(dreg(n, p)));
        chk("R7 c0 data", commit0_data, val(n, p));
        if (p + 1 < n) begin
          chk("R7 c1 we", 32'(commit1_we), 1);
          chk("R7 c1 reg", 32'(commit1_reg), 32'(dreg(n, p + 1)));
          chk("R7 c1 data", commit1_data, val(n, p + 1));
        end else begin
          chk("R8 c1 idle", 32'(commit1_we), 0);
        end
        @(posedge clk);
      end
      @(negedge clk); #1;
      chk("R6 drained", 32'(commit0_we), 0);
      chk("R3 freed", 32'(alloc_ready), 1);
      base = base + n;
      @(posedge clk);
    end

    @(negedge clk);
    alloc_valid = 1'b1; alloc_dest = 4'd5; alloc_ret = 1'b1;
    #1;
    chk("R9 R10 ret tag", 32'(alloc_tag), 32'(base % 8));
    @(posedge clk);
    @(negedge clk);
    alloc_dest = 4'd9; alloc_ret = 1'b0;
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 1'b0;
    wb0_valid = 1'b1; wb0_tag = 3'(base % 8); wb0_data = 32'h0;
    wb1_valid = 1'b1; wb1_tag = 3'((base + 1) % 8); wb1_data = 32'h55;
    #1;
    chk("R9 not yet", 32'(commit0_we), 0);
    @(posedge clk);
    @(negedge clk);
    wb0_valid = 1'b0; wb1_valid = 1'b0;
    #1;
    chk("R9 ret no write", 32'(commit0_we), 0);
    chk("R9 next held", 32'(commit1_we), 0);
    chk("R9 done late", 32'(done), 0);
    @(posedge clk);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk("R9 done", 32'(done), 1);
      chk("R9 quiet c0", 32'(commit0_we), 0);
      chk("R9 quiet c1", 32'(commit1_we), 0);
      @(posedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule